// File: doc/BRIEF.md
# Dual-Channel Event-Driven PWM Generator

This block produces two pulse-width modulated outputs, A and B, from one shared time base. A power-of-two prescaler slows the input clock into counting ticks. On each tick a 16-bit counter moves one step in one of four modes: up, down, up-down (triangle) or frozen. Each output is driven by a small rule table. For each of three counter events (reaching zero, reaching compare A while rising, and reaching compare B while rising) the table says whether to leave the output alone, force it low, force it high or invert it.

Both compare values can be double-buffered. With buffering on, software writes go to a holding copy, and the copy moves into the working value when the counter reaches zero, reaches the period, reaches either, or never. With buffering off, a write takes hold at once. Software programs everything through a 16-bit write port and a separate read port. A common setup is set-at-zero and clear-at-compare-A, which gives a duty of compare/(period+1).

The direction of the time base is a two-state machine. `DIR_UP` moves to `DIR_DOWN` on the *turn at period* transition: an up-down step taken while the count is at or above the period. `DIR_DOWN` moves back to `DIR_UP` on the *turn at zero* transition: an up-down step taken from zero. Up mode forces `DIR_UP` and down mode forces `DIR_DOWN` on every step. Frozen mode leaves the state alone.

Top module: `pwm_dual_aq`

## Requirements
- R1: After reset the mode reads 3 (frozen), every other register and the counter read 0, and both outputs are low.
- R2: The control register at address 0 holds the mode in bits [1:0] and the prescale index k in bits [4:2]. The counter steps once every 2^k clocks. A write to address 0 restarts the prescale count, so the first step under the new setting comes 2^k clocks after the write edge.
- R3: In mode 0 (up) the counter steps 0,1,…,P and then returns to 0, where P is the period register at address 1. A count already above P returns to 0 on its next step.
- R4: In mode 1 (down) the counter steps P,…,1,0 and then reloads P.
- R5: In mode 2 (up-down) the counter rises to P, turns and falls to 0, then turns and rises again. Compare events count only on rising steps.
- R6: In mode 3 (frozen) the counter and both outputs hold their values.
- R7: Each action register holds three 2-bit fields: zero event in [1:0], compare-A-up in [3:2], compare-B-up in [5:4]. Code 0 leaves the output alone, 1 forces it low, 2 forces it high and 3 inverts it. Channel A's register is at address 5 and channel B's at address 6. An event is judged on the value the counter steps into.
- R8: When several events fall on the same step, the first non-zero action in the order compare B, compare A, zero is the one applied.
- R9: Address 4 holds the buffering controls. Channel A uses bit 0 (enable) and bits [2:1] (load select). Channel B uses bit 3 and bits [5:4]. Load select 0 transfers on stepping into zero, 1 on stepping into P, 2 on either, 3 never. With buffering on, a write to address 2 (A) or 3 (B) changes only the holding copy.
- R10: With buffering off, a compare write is visible in the working value from the next clock.
- R11: With set-at-zero and clear-at-compare-A, a compare of 0 gives a constant low output and a compare above P gives a constant high output.
- R12: Reads return: 0 control, 1 period, 2 working compare A, 3 working compare B, 4 buffering controls, 5 and 6 action registers, 7 the counter. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational from rd_addr |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
A register write is visible on `rd_data` one clock after the edge that samples it. A counter step and any output change it causes appear on the same edge as a prescaler tick. The first tick after a control write lands 2^k edges after that write. The bench's behavioural model updates at every rising edge from the inputs held stable across it. It compares both outputs and the addressed read value at the following falling edge. Directed checks are sampled just after the edge on which the counted number of cycles ends.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_UPDOWN = 2'd2,
        MODE_FROZEN = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        LD_ZERO   = 2'd0,
        LD_PERIOD = 2'd1,
        LD_EITHER = 2'd2,
        LD_NEVER  = 2'd3
    } load_sel_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // on_zero occupies the low two bits
    typedef struct packed {
        act_e on_b;
        act_e on_a;
        act_e on_zero;
    } act_cfg_t;

    localparam int          ADDR_W   = 3;
    localparam int          NUM_CH   = 2;
    localparam logic [2:0]  A_CTRL   = 3'd0;
    localparam logic [2:0]  A_PRD    = 3'd1;
    localparam logic [2:0]  A_CMPA   = 3'd2;
    localparam logic [2:0]  A_CMPB   = 3'd3;
    localparam logic [2:0]  A_CMPCTL = 3'd4;
    localparam logic [2:0]  A_ACTA   = 3'd5;
    localparam logic [2:0]  A_ACTB   = 3'd6;
    localparam logic [2:0]  A_CNT    = 3'd7;

endpackage

// File: rtl/pwm_aq_prescale.sv
module pwm_aq_prescale #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] div_idx,
    input  logic             restart,
    output logic             tick
);
    localparam int PC_W = (1 << IDX_W) - 1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] lim;

    always_comb lim = PC_W'((32'd1 << div_idx) - 32'd1);

    assign tick = (pc_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               pc_q <= '0;
        else if (restart || tick) pc_q <= '0;
        else                      pc_q <= pc_q + 1'b1;
    end
endmodule

// File: rtl/pwm_aq_timebase.sv
module pwm_aq_timebase
    import pwm_aq_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  cnt_mode_e     mode,
    input  logic [CW-1:0] prd,
    output logic [CW-1:0] cnt,
    output logic          step_en,
    output logic [CW-1:0] nxt_cnt,
    output logic          step_up
);
    dir_e          dir_q, dir_d;
    logic [CW-1:0] cnt_q;

    assign step_en = tick && (mode != MODE_FROZEN);
    assign cnt     = cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= '0;
        end else if (step_en) begin
            dir_q <= dir_d;
            cnt_q <= nxt_cnt;
        end
    end

    // next state and step outputs
    always_comb begin
        dir_d   = dir_q;
        nxt_cnt = cnt_q;
        step_up = 1'b0;
        unique case (mode)
            MODE_UP: begin
                dir_d   = DIR_UP;
                step_up = 1'b1;
                nxt_cnt = (cnt_q >= prd) ? '0 : cnt_q + 1'b1;
            end
            MODE_DOWN: begin
                dir_d   = DIR_DOWN;
                nxt_cnt = (cnt_q == '0) ? prd : cnt_q - 1'b1;
            end
            MODE_UPDOWN: begin
                if (prd == '0) begin
                    dir_d   = DIR_UP;
                    step_up = 1'b1;
                    nxt_cnt = '0;
                end else begin
                    unique case (dir_q)
                        DIR_UP: begin
                            if (cnt_q >= prd) begin
                                dir_d   = DIR_DOWN;
                                nxt_cnt = cnt_q - 1'b1;
                            end else begin
                                step_up = 1'b1;
                                nxt_cnt = cnt_q + 1'b1;
                            end
                        end
                        DIR_DOWN: begin
                            if (cnt_q == '0) begin
                                dir_d   = DIR_UP;
                                step_up = 1'b1;
                                nxt_cnt = CW'(1);
                            end else begin
                                nxt_cnt = cnt_q - 1'b1;
                            end
                        end
                    endcase
                end
            end
            MODE_FROZEN: begin
                nxt_cnt = cnt_q;
            end
        endcase
    end
endmodule

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
    import pwm_aq_pkg::*;
#(
    parameter int CW    = 16,
    parameter int IDX_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CW-1:0]           wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [CW-1:0]           rd_data,
    input  logic [CW-1:0]           cnt,
    input  logic                    step_en,
    input  logic [CW-1:0]           nxt_cnt,
    output cnt_mode_e               mode,
    output logic [IDX_W-1:0]        div_idx,
    output logic                    ctrl_wr,
    output logic [CW-1:0]           prd,
    output logic [NUM_CH-1:0][CW-1:0] cmp_v,
    output act_cfg_t                act_a,
    output act_cfg_t                act_b
);
    localparam int CTL_W  = 3;
    localparam int CCTL_W = CTL_W * NUM_CH;

    logic              hit_zero, hit_prd;
    logic [CCTL_W-1:0] cmpctl_rd;

    assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
    assign hit_zero = step_en && (nxt_cnt == '0);
    assign hit_prd  = step_en && (nxt_cnt == prd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode    <= MODE_FROZEN;
            div_idx <= '0;
            prd     <= '0;
            act_a   <= '0;
            act_b   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    mode    <= cnt_mode_e'(wr_data[1:0]);
                    div_idx <= wr_data[IDX_W+1:2];
                end
                A_PRD:   prd   <= wr_data;
                A_ACTA:  act_a <= act_cfg_t'(wr_data[5:0]);
                A_ACTB:  act_b <= act_cfg_t'(wr_data[5:0]);
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
        logic          shen_q;
        load_sel_e     lsel_q;
        logic [CW-1:0] shd_q, act_q;
        logic          ld_hit, wr_cmp;

        assign wr_cmp = wr_en && (wr_addr == (A_CMPA + 3'(i)));
        assign cmp_v[i] = act_q;
        assign cmpctl_rd[CTL_W*i +: CTL_W] = {lsel_q, shen_q};

        always_comb begin
            unique case (lsel_q)
                LD_ZERO:   ld_hit = hit_zero;
                LD_PERIOD: ld_hit = hit_prd;
                LD_EITHER: ld_hit = hit_zero || hit_prd;
                LD_NEVER:  ld_hit = 1'b0;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shen_q <= 1'b0;
                lsel_q <= LD_ZERO;
                shd_q  <= '0;
                act_q  <= '0;
            end else begin
                if (wr_en && (wr_addr == A_CMPCTL)) begin
                    shen_q <= wr_data[CTL_W*i];
                    lsel_q <= load_sel_e'(wr_data[CTL_W*i+1 +: 2]);
                end
                if (wr_cmp) begin
                    shd_q <= wr_data;
                end
                if (wr_cmp && !shen_q) begin
                    act_q <= wr_data;
                end else if (shen_q && ld_hit) begin
                    act_q <= shd_q;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: begin
                rd_data[1:0]       = mode;
                rd_data[IDX_W+1:2] = div_idx;
            end
            A_PRD:    rd_data = prd;
            A_CMPA:   rd_data = cmp_v[0];
            A_CMPB:   rd_data = cmp_v[1];
            A_CMPCTL: rd_data[CCTL_W-1:0] = cmpctl_rd;
            A_ACTA:   rd_data[5:0] = act_a;
            A_ACTB:   rd_data[5:0] = act_b;
            A_CNT:    rd_data = cnt;
        endcase
    end
endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
    import pwm_aq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step_en,
    input  logic     ev_zero,
    input  logic     ev_a,
    input  logic     ev_b,
    input  act_cfg_t cfg,
    output logic     pwm
);
    act_e sel;

    // compare B first, then compare A, then zero
    always_comb begin
        sel = ACT_NONE;
        if (step_en) begin
            if (ev_b && (cfg.on_b != ACT_NONE))      sel = cfg.on_b;
            else if (ev_a && (cfg.on_a != ACT_NONE)) sel = cfg.on_a;
            else if (ev_zero)                        sel = cfg.on_zero;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else begin
            unique case (sel)
                ACT_NONE:   pwm <= pwm;
                ACT_LOW:    pwm <= 1'b0;
                ACT_HIGH:   pwm <= 1'b1;
                ACT_TOGGLE: pwm <= ~pwm;
            endcase
        end
    end
endmodule

// File: rtl/pwm_dual_aq.sv
module pwm_dual_aq
    import pwm_aq_pkg::*;
#(
    parameter int CW    = 16,
    parameter int IDX_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    output logic          pwm_a,
    output logic          pwm_b
);
    cnt_mode_e                 mode;
    logic [IDX_W-1:0]          div_idx;
    logic                      ctrl_wr, tick;
    logic [CW-1:0]             prd, cnt, nxt_cnt;
    logic                      step_en, step_up, ev_zero;
    logic [NUM_CH-1:0][CW-1:0] cmp_v;
    logic [NUM_CH-1:0]         ev_hit, pwm_q;
    act_cfg_t                  act_a, act_b;
    act_cfg_t                  cfg_v [NUM_CH];

    pwm_aq_regs #(.CW(CW), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt(cnt), .step_en(step_en), .nxt_cnt(nxt_cnt),
        .mode(mode), .div_idx(div_idx), .ctrl_wr(ctrl_wr),
        .prd(prd), .cmp_v(cmp_v), .act_a(act_a), .act_b(act_b)
    );

    pwm_aq_prescale #(.IDX_W(IDX_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .div_idx(div_idx),
        .restart(ctrl_wr), .tick(tick)
    );

    pwm_aq_timebase #(.CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .prd(prd),
        .cnt(cnt), .step_en(step_en), .nxt_cnt(nxt_cnt), .step_up(step_up)
    );

    assign ev_zero  = (nxt_cnt == '0);
    assign cfg_v[0] = act_a;
    assign cfg_v[1] = act_b;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ev_hit[i] = step_up && (nxt_cnt == cmp_v[i]);

        pwm_aq_chan u_ch (
            .clk(clk), .rst_n(rst_n), .step_en(step_en),
            .ev_zero(ev_zero), .ev_a(ev_hit[0]), .ev_b(ev_hit[1]),
            .cfg(cfg_v[i]), .pwm(pwm_q[i])
        );
    end

    assign pwm_a = pwm_q[0];
    assign pwm_b = pwm_q[1];
endmodule

// File: rtl/pwm_dual_aq_chk.sv
module pwm_dual_aq_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] prd,
    input logic [1:0]    mode,
    input logic          tick,
    input logic          pwm_a,
    input logic          pwm_b
);
    // R6
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> ($stable(cnt) && $stable(pwm_a) && $stable(pwm_b)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && $stable(pwm_a) && $stable(pwm_b)));

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == 2'd0 && cnt < prd) |=> (cnt == $past(cnt) + 1'b1));

    // R3
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == 2'd0 && cnt >= prd) |=> (cnt == '0));

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == 2'd1 && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R4
    down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == 2'd1 && cnt == '0) |=> (cnt == $past(prd)));
endmodule

bind pwm_dual_aq pwm_dual_aq_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .prd(prd), .mode(mode),
    .tick(tick), .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/sim_pwm_dual_aq.sv
`timescale 1ns/1ps
module sim_pwm_dual_aq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        pwm_a, pwm_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    pwm_dual_aq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // behavioural reference
    int m_cnt, m_pc, m_dir, m_mode, m_idx, m_prd;
    int m_act[2], m_shd[2], m_shen[2], m_lsel[2], m_cfg[2], m_pwm[2];

    function automatic int mread(input int a);
        case (a)
            0: return m_mode | (m_idx << 2);
            1: return m_prd;
            2: return m_act[0];
            3: return m_act[1];
            4: return m_shen[0] | (m_lsel[0] << 1) | (m_shen[1] << 3) | (m_lsel[1] << 4);
            5: return m_cfg[0];
            6: return m_cfg[1];
            default: return m_cnt;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pc = 0; m_dir = 0; m_mode = 3; m_idx = 0; m_prd = 0;
            for (int i = 0; i < 2; i++) begin
                m_act[i] = 0; m_shd[i] = 0; m_shen[i] = 0;
                m_lsel[i] = 0; m_cfg[i] = 0; m_pwm[i] = 0;
            end
        end else begin
            bit tick, step, up, ze, ld, hz, hp;
            int nc, nd, sel, d;
            bit ev[2];
            tick = (m_pc == (1 << m_idx) - 1);
            step = tick && (m_mode != 3);
            nc = m_cnt; nd = m_dir; up = 0;
            if (step) begin
                if (m_mode == 0) begin
                    nd = 0; up = 1; nc = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
                end else if (m_mode == 1) begin
                    nd = 1; nc = (m_cnt == 0) ? m_prd : m_cnt - 1;
                end else if (m_prd == 0) begin
                    nd = 0; up = 1; nc = 0;
                end else if (m_dir == 0) begin
                    if (m_cnt >= m_prd) begin nd = 1; nc = m_cnt - 1; end
                    else begin up = 1; nc = m_cnt + 1; end
                end else begin
                    if (m_cnt == 0) begin nd = 0; up = 1; nc = 1; end
                    else nc = m_cnt - 1;
                end
            end
            ze = step && (nc == 0);
            hz = ze;
            hp = step && (nc == m_prd);
            for (int i = 0; i < 2; i++) ev[i] = step && up && (nc == m_act[i]);
            for (int i = 0; i < 2; i++) begin
                sel = 0;
                if (ev[1] && ((m_cfg[i] >> 4) & 3) != 0) sel = (m_cfg[i] >> 4) & 3;
                else if (ev[0] && ((m_cfg[i] >> 2) & 3) != 0) sel = (m_cfg[i] >> 2) & 3;
                else if (ze) sel = m_cfg[i] & 3;
                if (sel == 1) m_pwm[i] = 0;
                else if (sel == 2) m_pwm[i] = 1;
                else if (sel == 3) m_pwm[i] = 1 - m_pwm[i];
            end
            for (int i = 0; i < 2; i++) begin
                ld = (m_lsel[i] == 0) ? hz : (m_lsel[i] == 1) ? hp :
                     (m_lsel[i] == 2) ? (hz || hp) : 1'b0;
                if (m_shen[i] != 0 && ld) m_act[i] = m_shd[i];
            end
            if (step) begin m_cnt = nc; m_dir = nd; end
            if ((wr_en && wr_addr == 0) || tick) m_pc = 0; else m_pc = m_pc + 1;
            if (wr_en) begin
                d = int'(wr_data);
                case (wr_addr)
                    0: begin m_mode = d & 3; m_idx = (d >> 2) & 7; end
                    1: m_prd = d;
                    2, 3: begin
                        m_shd[wr_addr - 2] = d;
                        if (m_shen[wr_addr - 2] == 0) m_act[wr_addr - 2] = d;
                    end
                    4: begin
                        m_shen[0] = d & 1; m_lsel[0] = (d >> 1) & 3;
                        m_shen[1] = (d >> 3) & 1; m_lsel[1] = (d >> 4) & 3;
                    end
                    5: m_cfg[0] = d & 63;
                    6: m_cfg[1] = d & 63;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "pwm_a vs model", int'(pwm_a), m_pwm[0]);
            chk(cur_req, "pwm_b vs model", int'(pwm_b), m_pwm[1]);
            chk(cur_req, "rd_data vs model", int'(rd_data), mread(int'(rd_addr)));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 3'(a); #0.5;
        v = int'(rd_data);
    endtask

    task automatic count_hi(input int n, input bit chb, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            cyc(1);
            hi += chb ? int'(pwm_b) : int'(pwm_a);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v, c0, hi;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        cur_req = "R1";
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            chk("R1", "reset register", v, (a == 0) ? 3 : 0);
        end
        chk("R1", "reset pwm_a", int'(pwm_a), 0);
        chk("R1", "reset pwm_b", int'(pwm_b), 0);

        // R12 map readback, R10 immediate compare
        cur_req = "R12";
        wr(1, 7); wr(5, 6); wr(2, 3);
        rd(1, v); chk("R12", "period read", v, 7);
        rd(5, v); chk("R12", "action A read", v, 6);
        rd(2, v); chk("R10", "compare A immediate", v, 3);
        rd(4, v); chk("R12", "buffer ctl read", v, 0);

        // R3 up counting, R11 typical duty
        cur_req = "R3";
        rd_addr = 3'd7;
        wr(0, 0);
        cyc(12);
        rd(7, c0); cyc(1); rd(7, v);
        chk("R3", "up step", v, (c0 + 1) % 8);
        count_hi(16, 0, hi); chk("R11", "duty 3/8", hi, 6);
        cur_req = "R11";
        wr(2, 0); cyc(10); count_hi(16, 0, hi); chk("R11", "compare 0 gives low", hi, 0);
        wr(2, 8); cyc(10); count_hi(16, 0, hi); chk("R11", "compare above P gives high", hi, 16);

        // R7 action codes
        cur_req = "R7";
        wr(5, 3); cyc(10); count_hi(16, 0, hi); chk("R7", "toggle at zero", hi, 8);
        wr(5, 1); cyc(10); chk("R7", "force low", int'(pwm_a), 0);
        wr(5, 2); cyc(10); chk("R7", "force high", int'(pwm_a), 1);
        wr(5, 0); count_hi(16, 0, hi); chk("R7", "none holds", hi, 16);

        // R8 priority
        cur_req = "R8";
        wr(2, 0); wr(3, 0);
        wr(6, 54); cyc(10); count_hi(16, 1, hi); chk("R8", "B wins toggle", hi, 8);
        wr(6, 6);  cyc(10); count_hi(16, 1, hi); chk("R8", "A beats zero", hi, 0);
        wr(6, 2);  cyc(10); count_hi(16, 1, hi); chk("R8", "zero alone", hi, 16);

        // R2 prescaler
        cur_req = "R2";
        rd_addr = 3'd7;
        wr(0, 8);
        rd(7, c0);
        cyc(3); rd(7, v); chk("R2", "hold before tick", v, c0);
        cyc(1); rd(7, v); chk("R2", "step on 4th clock", v, (c0 + 1) % 8);
        cyc(64);

        // R4 down counting
        cur_req = "R4";
        wr(0, 1); cyc(5);
        rd(7, c0); cyc(1); rd(7, v);
        chk("R4", "down step", v, (c0 == 0) ? 7 : c0 - 1);
        cyc(30);

        // R5 up-down, compare only while rising
        cur_req = "R5";
        wr(5, 6); wr(2, 3); wr(0, 2);
        cyc(30);
        count_hi(28, 0, hi); chk("R5", "triangle duty 3/14", hi, 6);
        rd_addr = 3'd7;
        for (int k = 0; k < 40 && rd_data != 16'd7; k++) cyc(1);
        rd(7, v); chk("R5", "reach period", v, 7);
        cyc(1); rd(7, v); chk("R5", "turn at period", v, 6);

        // R9 buffered compares
        cur_req = "R9";
        wr(0, 0);
        wr(4, 3); wr(2, 5);
        rd(2, v); chk("R9", "buffered write hidden", v, 3);
        cyc(9); rd(2, v); chk("R9", "load at period", v, 5);
        wr(4, 7); wr(2, 2); cyc(20);
        rd(2, v); chk("R9", "never loads", v, 5);
        wr(4, 1); cyc(9); rd(2, v); chk("R9", "load at zero", v, 2);
        wr(4, 5); wr(2, 6); cyc(9); rd(2, v); chk("R9", "load at either", v, 6);
        wr(4, 24); wr(3, 4);
        rd(3, v); chk("R9", "B buffered write hidden", v, 0);
        cyc(9); rd(3, v); chk("R9", "B load at period", v, 4);

        // R10 unbuffered
        cur_req = "R10";
        wr(4, 0); wr(2, 1);
        rd(2, v); chk("R10", "unbuffered write visible", v, 1);

        // R6 frozen
        cur_req = "R6";
        wr(0, 3);
        rd(7, c0); hi = int'(pwm_b);
        cyc(20);
        rd(7, v); chk("R6", "counter frozen", v, c0);
        chk("R6", "output frozen", int'(pwm_b), hi);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule